// File: doc/BRIEF.md
# Multi-condition trigger selector

The selector looks at a set of pre-computed physics estimators on every clock: a calorimeter energy sum, a positron direction difference, a signed time difference between the photon and the positron, and the charges seen at the left and right ends of a timing counter. It compares them against programmable thresholds and forms up to 32 trigger conditions, one per trigger slot. Each slot can be enabled on its own and thinned out by its own wide prescaler. The slots that survive form a 32-bit pattern word. A registered trigger pulse goes out together with that pattern and a running event number, so that the digitizers can tag the data they record.

Several slots reuse the same comparisons. The main coincidence needs high energy, a narrow direction cut and a narrow time window. Three companion slots each relax exactly one of these three cuts. A window slot accepts energies between the two energy thresholds. A counter slot needs both ends of the timing counter above a per-side threshold and their sum above a sum threshold. The last slot is a pedestal trigger taken from a free-running pseudo-random sequence.

While the downstream readout is busy, no trigger is issued and dead time is counted. Otherwise live time is counted. A per-slot rate counter records how often each condition is met. All registers are reached through a simple single-cycle read/write bus.

Top module: `trig_sel`

## Requirements
- R1: After reset the trigger output is low, the pattern and event number are 0, all slots are disabled, and all thresholds, prescale factors and counters read 0.
- R2: Slot 0 is met when energy > high threshold, direction < narrow limit and |time| < narrow window. All comparisons are unsigned, and time is a two's-complement value.
- R3: Slot 1 is slot 0 with the low energy threshold instead of the high one. Slot 2 is slot 0 with the wide direction limit. Slot 3 is slot 0 with the wide time window.
- R4: Slot 11 is met when low threshold < energy < high threshold. Slot 11 therefore never shows in the same pattern as slot 0.
- R5: Slot 22 is met when the left charge and the right charge are both above the per-side threshold and their sum (computed one bit wider) is above the sum threshold.
- R6: Slot 31 is met when the low 8 bits of a 32-bit state S equal the low 8 bits of the pedestal match register. S is 1 at reset and steps on every clock to (S >> 1) XOR (0xA3000000 if S[0] else 0). All other slots are never met.
- R7: Bit i of the enable register enables slot i. A disabled slot never sets its pattern bit.
- R8: A slot with prescale factor N passes only every Nth qualifying cycle; a factor of 0 acts as 1. Writing a slot's factor restarts its count.
- R9: The pattern and the trigger appear one clock after the inputs that caused them. The pattern holds one bit per slot that passed. The trigger is high exactly when the pattern is non-zero.
- R10: Each trigger carries the current event count on the event number output, starting at 0. The count then steps by one.
- R11: While busy is high, no pattern bit is set, prescale counts hold, and the dead-time counter steps by one per clock. In every clock without busy, the live-time counter steps by one instead.
- R12: The rate counter of a slot steps on every clock in which its condition is met, whatever its enable, prescale or busy state.
- R13: Bus map: 0x00+i holds the prescale factor of slot i. 0x20+i holds the rate counter of slot i. 0x40 is the enable register. 0x41 is the high energy threshold and 0x42 the low one. 0x43 is the narrow direction limit and 0x44 the wide one. 0x45 is the narrow time window and 0x46 the wide one. 0x47 is the per-side charge threshold and 0x48 the charge sum threshold. 0x49 is the pedestal match, 0x4A the event count, 0x4B live time and 0x4C dead time. Counters are read-only, and writes to them have no effect. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| energy_i | input | EW | Energy sum estimator |
| dir_i | input | EW | Direction difference estimator |
| tdiff_i | input | EW | Signed time difference estimator |
| qleft_i | input | EW | Left counter charge |
| qright_i | input | EW | Right counter charge |
| busy_i | input | 1 | Readout busy, blocks triggers |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | CW | Register write data |
| bus_rdata_o | output | CW | Register read data |
| trig_o | output | 1 | Trigger pulse |
| pattern_o | output | 32 | Slots that passed |
| event_num_o | output | CW | Event number of the trigger |

## Verification
The most delicate overlap is a qualifying condition meeting a high busy input in the same cycle. The trigger must be suppressed and the prescale count must freeze, yet the rate counter must still step. The bench sets a prescale factor of 4, holds a qualifying input through ten busy cycles, and then expects the pass on exactly the fourth clock after busy drops. It also measures the dead-time and live-time differences across that interval. A second overlap is a write to the enable register or a prescale factor landing in a cycle in which the slot qualifies. Such a cycle is judged only through the event-number monitor, which checks every trigger whenever it occurs.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
    localparam int NT     = 32;
    localparam int ADDR_W = 7;

    localparam int SL_MAIN  = 0;
    localparam int SL_LOWE  = 1;
    localparam int SL_WIDED = 2;
    localparam int SL_WIDET = 3;
    localparam int SL_EWIN  = 11;
    localparam int SL_CNT   = 22;
    localparam int SL_PED   = 31;

    localparam logic [ADDR_W-1:0] A_MASK  = 7'h40;
    localparam logic [ADDR_W-1:0] A_EHI   = 7'h41;
    localparam logic [ADDR_W-1:0] A_ELO   = 7'h42;
    localparam logic [ADDR_W-1:0] A_DN    = 7'h43;
    localparam logic [ADDR_W-1:0] A_DW    = 7'h44;
    localparam logic [ADDR_W-1:0] A_TN    = 7'h45;
    localparam logic [ADDR_W-1:0] A_TW    = 7'h46;
    localparam logic [ADDR_W-1:0] A_QSIDE = 7'h47;
    localparam logic [ADDR_W-1:0] A_QSUM  = 7'h48;
    localparam logic [ADDR_W-1:0] A_PED   = 7'h49;
    localparam logic [ADDR_W-1:0] A_EVT   = 7'h4A;
    localparam logic [ADDR_W-1:0] A_LIVE  = 7'h4B;
    localparam logic [ADDR_W-1:0] A_DEAD  = 7'h4C;
endpackage

// File: rtl/trig_lfsr.sv
module trig_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'hA300_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) state_d = state_d ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W'(1);
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/trig_cond.sv
module trig_cond
    import trig_sel_pkg::*;
#(
    parameter int EW = 16,
    parameter int LW = 32,
    parameter int PW = 8
) (
    input  logic [EW-1:0] energy_i,
    input  logic [EW-1:0] dir_i,
    input  logic [EW-1:0] tdiff_i,
    input  logic [EW-1:0] qleft_i,
    input  logic [EW-1:0] qright_i,
    input  logic [EW-1:0] e_hi_i,
    input  logic [EW-1:0] e_lo_i,
    input  logic [EW-1:0] d_n_i,
    input  logic [EW-1:0] d_w_i,
    input  logic [EW-1:0] t_n_i,
    input  logic [EW-1:0] t_w_i,
    input  logic [EW-1:0] q_side_i,
    input  logic [EW-1:0] q_sum_i,
    input  logic [LW-1:0] rnd_i,
    input  logic [PW-1:0] ped_i,
    output logic [NT-1:0] cond_o
);
    localparam logic [LW-1:0] LMASK = LW'((64'd1 << PW) - 64'd1);

    logic [EW:0] tmag, qtot;
    logic e_gt_hi, e_gt_lo, e_lt_hi, d_lt_n, d_lt_w, t_lt_n, t_lt_w, ped_hit;

    always_comb begin
        tmag    = tdiff_i[EW-1] ? ({1'b0, ~tdiff_i} + (EW+1)'(1)) : {1'b0, tdiff_i};
        qtot    = {1'b0, qleft_i} + {1'b0, qright_i};
        e_gt_hi = energy_i > e_hi_i;
        e_gt_lo = energy_i > e_lo_i;
        e_lt_hi = energy_i < e_hi_i;
        d_lt_n  = dir_i < d_n_i;
        d_lt_w  = dir_i < d_w_i;
        t_lt_n  = tmag < {1'b0, t_n_i};
        t_lt_w  = tmag < {1'b0, t_w_i};
        ped_hit = (rnd_i & LMASK) == LW'(ped_i);

        cond_o           = '0;
        cond_o[SL_MAIN]  = e_gt_hi & d_lt_n & t_lt_n;
        cond_o[SL_LOWE]  = e_gt_lo & d_lt_n & t_lt_n;
        cond_o[SL_WIDED] = e_gt_hi & d_lt_w & t_lt_n;
        cond_o[SL_WIDET] = e_gt_hi & d_lt_n & t_lt_w;
        cond_o[SL_EWIN]  = e_gt_lo & e_lt_hi;
        cond_o[SL_CNT]   = (qleft_i > q_side_i) & (qright_i > q_side_i)
                         & (qtot > {1'b0, q_sum_i});
        cond_o[SL_PED]   = ped_hit;
    end
endmodule

// File: rtl/trig_prescale.sv
module trig_prescale
    import trig_sel_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] qual_i,
    input  logic [NT-1:0] clr_i,
    input  logic [CW-1:0] factor_i [NT],
    output logic [NT-1:0] pass_o
);
    logic [CW-1:0] cnt_d [NT];
    logic [CW-1:0] cnt_q [NT];
    logic [CW:0]   eff;

    always_comb begin
        pass_o = '0;
        eff    = '0;
        for (int i = 0; i < NT; i++) begin
            cnt_d[i] = cnt_q[i];
            eff = (factor_i[i] == '0) ? (CW+1)'(1) : {1'b0, factor_i[i]};
            if (clr_i[i]) begin
                cnt_d[i] = '0;
            end else if (qual_i[i]) begin
                if (({1'b0, cnt_q[i]} + (CW+1)'(1)) >= eff) begin
                    pass_o[i] = 1'b1;
                    cnt_d[i]  = '0;
                end else begin
                    cnt_d[i] = cnt_q[i] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < NT; i++) cnt_q[i] <= cnt_d[i];
        end
    end
endmodule

// File: rtl/trig_sel.sv
module trig_sel
    import trig_sel_pkg::*;
#(
    parameter int EW = 16,
    parameter int CW = 32,
    parameter int PW = 8,
    parameter int LW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EW-1:0]     energy_i,
    input  logic [EW-1:0]     dir_i,
    input  logic [EW-1:0]     tdiff_i,
    input  logic [EW-1:0]     qleft_i,
    input  logic [EW-1:0]     qright_i,
    input  logic              busy_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CW-1:0]     bus_wdata_i,
    output logic [CW-1:0]     bus_rdata_o,
    output logic              trig_o,
    output logic [NT-1:0]     pattern_o,
    output logic [CW-1:0]     event_num_o
);
    typedef struct packed {
        logic [NT-1:0] mask;
        logic [EW-1:0] e_hi, e_lo, d_n, d_w, t_n, t_w, q_side, q_sum;
        logic [PW-1:0] ped;
        logic [CW-1:0] evt, live, dead, evnum;
        logic          trig;
        logic [NT-1:0] pattern;
    } state_t;

    state_t        r_d, r_q;
    logic [CW-1:0] presc_d [NT];
    logic [CW-1:0] presc_q [NT];
    logic [CW-1:0] rate_d  [NT];
    logic [CW-1:0] rate_q  [NT];
    logic [NT-1:0] cond, qual, pass, presc_clr;
    logic [LW-1:0] rnd;
    logic [1:0]    page;
    logic [4:0]    slot;

    assign page = bus_addr_i[ADDR_W-1:5];
    assign slot = bus_addr_i[4:0];

    trig_lfsr #(.W(LW)) u_rnd (.clk(clk), .rst_n(rst_n), .state_o(rnd));

    trig_cond #(.EW(EW), .LW(LW), .PW(PW)) u_cond (
        .energy_i(energy_i), .dir_i(dir_i), .tdiff_i(tdiff_i),
        .qleft_i(qleft_i), .qright_i(qright_i),
        .e_hi_i(r_q.e_hi), .e_lo_i(r_q.e_lo), .d_n_i(r_q.d_n), .d_w_i(r_q.d_w),
        .t_n_i(r_q.t_n), .t_w_i(r_q.t_w), .q_side_i(r_q.q_side), .q_sum_i(r_q.q_sum),
        .rnd_i(rnd), .ped_i(r_q.ped), .cond_o(cond)
    );

    assign qual = cond & r_q.mask & {NT{~busy_i}};

    trig_prescale #(.CW(CW)) u_presc (
        .clk(clk), .rst_n(rst_n), .qual_i(qual), .clr_i(presc_clr),
        .factor_i(presc_q), .pass_o(pass)
    );

    always_comb begin
        r_d       = r_q;
        presc_clr = '0;
        for (int i = 0; i < NT; i++) begin
            presc_d[i] = presc_q[i];
            rate_d[i]  = cond[i] ? rate_q[i] + CW'(1) : rate_q[i];
        end
        if (bus_we_i) begin
            if (page == 2'd0) begin
                presc_d[slot]   = bus_wdata_i;
                presc_clr[slot] = 1'b1;
            end else begin
                case (bus_addr_i)
                    A_MASK:  r_d.mask   = bus_wdata_i[NT-1:0];
                    A_EHI:   r_d.e_hi   = bus_wdata_i[EW-1:0];
                    A_ELO:   r_d.e_lo   = bus_wdata_i[EW-1:0];
                    A_DN:    r_d.d_n    = bus_wdata_i[EW-1:0];
                    A_DW:    r_d.d_w    = bus_wdata_i[EW-1:0];
                    A_TN:    r_d.t_n    = bus_wdata_i[EW-1:0];
                    A_TW:    r_d.t_w    = bus_wdata_i[EW-1:0];
                    A_QSIDE: r_d.q_side = bus_wdata_i[EW-1:0];
                    A_QSUM:  r_d.q_sum  = bus_wdata_i[EW-1:0];
                    A_PED:   r_d.ped    = bus_wdata_i[PW-1:0];
                    default: ;
                endcase
            end
        end
        r_d.pattern = pass;
        r_d.trig    = |pass;
        if (|pass) begin
            r_d.evnum = r_q.evt;
            r_d.evt   = r_q.evt + CW'(1);
        end
        if (busy_i) r_d.dead = r_q.dead + CW'(1);
        else        r_d.live = r_q.live + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < NT; i++) begin
                presc_q[i] <= '0;
                rate_q[i]  <= '0;
            end
        end else begin
            r_q <= r_d;
            for (int i = 0; i < NT; i++) begin
                presc_q[i] <= presc_d[i];
                rate_q[i]  <= rate_d[i];
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (page == 2'd0) bus_rdata_o = presc_q[slot];
        else if (page == 2'd1) bus_rdata_o = rate_q[slot];
        else begin
            case (bus_addr_i)
                A_MASK:  bus_rdata_o = CW'(r_q.mask);
                A_EHI:   bus_rdata_o = CW'(r_q.e_hi);
                A_ELO:   bus_rdata_o = CW'(r_q.e_lo);
                A_DN:    bus_rdata_o = CW'(r_q.d_n);
                A_DW:    bus_rdata_o = CW'(r_q.d_w);
                A_TN:    bus_rdata_o = CW'(r_q.t_n);
                A_TW:    bus_rdata_o = CW'(r_q.t_w);
                A_QSIDE: bus_rdata_o = CW'(r_q.q_side);
                A_QSUM:  bus_rdata_o = CW'(r_q.q_sum);
                A_PED:   bus_rdata_o = CW'(r_q.ped);
                A_EVT:   bus_rdata_o = r_q.evt;
                A_LIVE:  bus_rdata_o = r_q.live;
                A_DEAD:  bus_rdata_o = r_q.dead;
                default: bus_rdata_o = '0;
            endcase
        end
    end

    assign trig_o      = r_q.trig;
    assign pattern_o   = r_q.pattern;
    assign event_num_o = r_q.evnum;

    logic [NT-1:0] mask_w;
    logic [CW-1:0] evt_w, live_w, dead_w;
    assign mask_w = r_q.mask;
    assign evt_w  = r_q.evt;
    assign live_w = r_q.live;
    assign dead_w = r_q.dead;
endmodule

// File: rtl/trig_sel_chk.sv
module trig_sel_chk #(
    parameter int CW = 32,
    parameter int NT = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_i,
    input logic          trig_o,
    input logic [NT-1:0] pattern_o,
    input logic [NT-1:0] mask_w,
    input logic [CW-1:0] evt_w,
    input logic [CW-1:0] evnum_w,
    input logic [CW-1:0] live_w,
    input logic [CW-1:0] dead_w
);
    // R11
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !trig_o);

    // R11
    dead_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> dead_w == $past(dead_w) + CW'(1));

    // R11
    live_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> live_w == $past(live_w) + CW'(1));

    // R7
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pattern_o & ~$past(mask_w)) == '0);

    // R10
    evt_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> evt_w == evnum_w + CW'(1));

    // R4
    win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pattern_o[11] && pattern_o[0]));
endmodule

bind trig_sel trig_sel_chk #(.CW(CW), .NT(trig_sel_pkg::NT)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .trig_o(trig_o),
    .pattern_o(pattern_o), .mask_w(mask_w), .evt_w(evt_w),
    .evnum_w(event_num_o), .live_w(live_w), .dead_w(dead_w)
);

// File: tb/sim_trig_sel.sv
module sim_trig_sel;
    localparam int TH_EHI = 100, TH_ELO = 50, TH_DN = 10, TH_DW = 20;
    localparam int TH_TN = 5, TH_TW = 12, TH_QS = 30, TH_QSUM = 100;

    logic        clk = 0, rst_n = 0;
    logic [15:0] energy = 0, dir = 0, tdiff = 0, ql = 0, qr = 0;
    logic        busy = 0, we = 0;
    logic [6:0]  addr = 0;
    logic [31:0] wdata = 0, rdata, pattern, evnum;
    logic        trig;

    int n_chk = 0, n_bad = 0;
    int evt_exp = 0;
    logic [31:0] m = 1, mp = 1;

    trig_sel u0 (
        .clk(clk), .rst_n(rst_n), .energy_i(energy), .dir_i(dir), .tdiff_i(tdiff),
        .qleft_i(ql), .qright_i(qr), .busy_i(busy), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .trig_o(trig), .pattern_o(pattern), .event_num_o(evnum)
    );

    always #4 clk = ~clk;

    // pseudo-random sequence model from the R6 definition
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m  <= 32'd1;
            mp <= 32'd1;
        end else begin
            mp <= m;
            m  <= m[0] ? ((m >> 1) ^ 32'hA300_0000) : (m >> 1);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: every trigger carries the next event number
    always @(negedge clk) begin
        if (rst_n && trig) begin
            chk(evnum == 32'(evt_exp), "R10 event number", evnum, evt_exp);
            evt_exp++;
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 0;
    endtask

    task automatic rd_now(input logic [6:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic cyc(input int e, input int d, input int t, input int l, input int r, input bit b);
        @(negedge clk);
        energy = 16'(e); dir = 16'(d); tdiff = 16'(t); ql = 16'(l); qr = 16'(r); busy = b;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] expp(int e, int d, int t, int l, int r);
        logic [31:0] p = '0;
        int ta = (t < 0) ? -t : t;
        p[0]  = (e > TH_EHI) && (d < TH_DN) && (ta < TH_TN);
        p[1]  = (e > TH_ELO) && (d < TH_DN) && (ta < TH_TN);
        p[2]  = (e > TH_EHI) && (d < TH_DW) && (ta < TH_TN);
        p[3]  = (e > TH_EHI) && (d < TH_DN) && (ta < TH_TW);
        p[11] = (e > TH_ELO) && (e < TH_EHI);
        p[22] = (l > TH_QS) && (r > TH_QS) && (l + r > TH_QSUM);
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, v0, v1, l0, l1, msk, e;
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(trig == 0, "R1 trigger", trig, 0);
        chk(pattern == 0, "R1 pattern", pattern, 0);
        chk(evnum == 0, "R1 event number", evnum, 0);
        rd_now(7'h40, v); chk(v == 0, "R1 enable", v, 0);
        rd_now(7'h41, v); chk(v == 0, "R1 threshold", v, 0);
        rd_now(7'h00, v); chk(v == 0, "R1 prescale", v, 0);
        rd_now(7'h20, v); chk(v == 0, "R1 rate", v, 0);
        rd_now(7'h4A, v); chk(v == 0, "R1 event count", v, 0);

        // R13 map and read-only counters
        wr(7'h4A, 32'h1234);
        rd(7'h4A, v); chk(v == 0, "R13 read-only event count", v, 0);
        wr(7'h4C, 32'h55);
        rd(7'h4C, v); chk(v == 0, "R13 read-only dead time", v, 0);
        wr(7'h41, TH_EHI); wr(7'h42, TH_ELO); wr(7'h43, TH_DN); wr(7'h44, TH_DW);
        wr(7'h45, TH_TN);  wr(7'h46, TH_TW);  wr(7'h47, TH_QS); wr(7'h48, TH_QSUM);
        rd(7'h46, v); chk(v == TH_TW, "R13 wide window readback", v, TH_TW);
        rd(7'h48, v); chk(v == TH_QSUM, "R13 sum threshold readback", v, TH_QSUM);

        // R2 R3 R4 R7 R9 sweep, slot 3 and slot 31 disabled
        msk = 32'h7FFF_FFF7;
        wr(7'h40, msk);
        rd(7'h23, v0);
        cnt = 0;
        for (int ee = 45; ee <= 105; ee++)
            for (int dd = 8; dd <= 21; dd++)
                for (int tt = -13; tt <= 13; tt++) begin
                    cyc(ee, dd, tt, 0, 0, 0);
                    e = expp(ee, dd, tt, 0, 0);
                    if (e[3]) cnt++;
                    e = e & msk;
                    chk(pattern == e, "R2 R3 R4 R7 sweep", pattern, e);
                    chk(trig == (e != 0), "R9 trigger vs pattern", trig, e != 0);
                end
        // R12 rate of a disabled slot
        rd(7'h23, v1); chk(v1 - v0 == 32'(cnt), "R12 rate of disabled slot 3", v1 - v0, cnt);

        // R5 counter slot sweep
        wr(7'h40, 32'h0040_0000);
        rd(7'h36, v0);
        cnt = 0;
        for (int a = 20; a <= 80; a++)
            for (int b = 20; b <= 80; b++) begin
                cyc(0, 0, 0, a, b, 0);
                e = expp(0, 0, 0, a, b);
                if (e[22]) cnt++;
                chk(pattern == e, "R5 counter slot", pattern, e);
            end
        rd(7'h36, v1); chk(v1 - v0 == 32'(cnt), "R12 rate of slot 22", v1 - v0, cnt);

        // R8 prescale
        cyc(0, 0, 0, 0, 0, 0);
        wr(7'h0B, 3);
        wr(7'h40, 32'h0000_0800);
        for (int k = 1; k <= 12; k++) begin
            cyc(75, 0, 0, 0, 0, 0);
            chk(pattern[11] == (k % 3 == 0), "R8 every third", pattern[11], k % 3 == 0);
        end
        wr(7'h0B, 0);
        for (int k = 1; k <= 3; k++) begin
            cyc(75, 0, 0, 0, 0, 0);
            chk(pattern[11] == 1, "R8 factor zero", pattern[11], 1);
        end

        // R11 busy overlapping a qualifying slot 0 with factor 4
        cyc(0, 0, 0, 0, 0, 0);
        wr(7'h00, 4);
        wr(7'h40, 32'h1);
        @(negedge clk);
        rd_now(7'h4C, v0); rd_now(7'h4B, l0);
        for (int k = 0; k < 10; k++) begin
            cyc(200, 0, 0, 0, 0, 1);
            chk(pattern == 0, "R11 busy blocks", pattern, 0);
        end
        @(negedge clk);
        rd_now(7'h4C, v1); rd_now(7'h4B, l1);
        chk(v1 - v0 == 10, "R11 dead time", v1 - v0, 10);
        chk(l1 - l0 == 1, "R11 live time", l1 - l0, 1);
        for (int k = 1; k <= 4; k++) begin
            cyc(200, 0, 0, 0, 0, 0);
            chk(pattern[0] == (k == 4), "R11 prescale held during busy", pattern[0], k == 4);
        end

        // R6 pedestal slot
        cyc(0, 0, 0, 0, 0, 0);
        wr(7'h49, 32'h5A);
        wr(7'h40, 32'h8000_0000);
        cnt = 0;
        for (int k = 0; k < 3000; k++) begin
            cyc(0, 0, 0, 0, 0, 0);
            e = (mp[7:0] == 8'h5A) ? 32'h8000_0000 : 32'h0;
            if (e != 0) cnt++;
            chk(pattern == e, "R6 pedestal", pattern, e);
        end
        chk(cnt > 0, "R6 pedestal fired", cnt, 1);

        rd(7'h4A, v); chk(v == 32'(evt_exp), "R10 event count register", v, evt_exp);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule